// File: doc/BRIEF.md
# SPI Receive Status and Match Detector

This block holds the receive-side status of a serial peripheral: a receive-full flag and a data-match flag. Each completed 8- or 16-bit frame arrives as a strobe with its value. The value is latched into a receive data register and the flag is raised. A programmable 16-bit match register is compared with the latched value. When they agree, and the receive-full flag is already up, the match flag rises one cycle after the receive-full flag. The serial shifter, clock generation and FIFO storage sit outside the block. Their events come in as strobes.

Software clears the receive-full flag with a handshake in two steps: a status read while the flag is set, then a data-register read. When receive DMA is enabled, a DMA-done pulse clears the flag instead. In FIFO mode the flag only mirrors the external FIFO-full indication. The match flag is cleared by a status read while it is set, followed by a write of one to its clear bit.

Two small state machines do the work. The receive-full machine has the states RF_EMPTY, RF_FULL and RF_ARMED:
- RF_EMPTY goes to RF_FULL on a frame.
- RF_FULL goes to RF_ARMED on a status read.
- RF_ARMED goes to RF_EMPTY on a data read outside DMA mode.
- RF_FULL or RF_ARMED goes to RF_EMPTY on DMA-done in DMA mode.
- A clear and a frame in the same cycle lead to RF_FULL.
- In FIFO mode the state is forced each cycle to RF_FULL or RF_EMPTY from the FIFO-full input.

The match machine has the states MF_CLEAR, MF_SET and MF_ARMED:
- MF_CLEAR goes to MF_SET on a match event.
- MF_SET goes to MF_ARMED on a status read.
- MF_ARMED goes to MF_CLEAR on a write of one, or to MF_SET if a new match event comes in that same cycle.

Top module: `spi_rx_status`

## Requirements
- R1: After reset, rx_full and match_flag are 0 and rx_data is 0.
- R2: Outside FIFO mode, frame_done loads frame_data into rx_data and sets rx_full, both visible in the next cycle.
- R3: Outside DMA and FIFO mode, rx_full clears after a stat_rd that sees it set, followed by a later or same-armed data_rd. A data_rd without that prior status read leaves rx_full set.
- R4: With dma_rx_en=1, dma_rx_done clears rx_full and data_rd has no effect. With dma_rx_en=0, dma_rx_done has no effect.
- R5: A frame_done in the same cycle as any clear of rx_full leaves rx_full set.
- R6: With fifo_mode=1, rx_full equals fifo_full delayed by one cycle, and frame_done does not set it.
- R7: match_flag is set one cycle after rx_full rises when rx_data equals the match register. A mismatch leaves it clear.
- R8: With wide_mode=0 only bits 7:0 are compared. With wide_mode=1 all 16 bits are compared.
- R9: match_flag clears after a stat_rd that sees it set, followed by a stat_wr with clr_match=1.
- R10: A stat_wr with clr_match=1 that no prior status read has armed leaves match_flag set.
- R11: Each frame is evaluated once. After a clear, match_flag stays 0 until a new frame matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_done | input | 1 | Completed frame strobe |
| frame_data | input | 16 | Value of the completed frame |
| wide_mode | input | 1 | 1: 16-bit frames, 0: 8-bit frames |
| fifo_mode | input | 1 | FIFO mode select |
| fifo_full | input | 1 | Receive FIFO full indication |
| dma_rx_en | input | 1 | Receive DMA enable |
| dma_rx_done | input | 1 | Receive DMA transfer done pulse |
| match_we | input | 1 | Match register write strobe |
| match_wdata | input | 16 | Match register write value |
| stat_rd | input | 1 | Status read strobe |
| data_rd | input | 1 | Data register read strobe |
| stat_wr | input | 1 | Status write strobe |
| clr_match | input | 1 | Status write data: match flag clear bit |
| rx_full | output | 1 | Receive-full flag |
| match_flag | output | 1 | Data-match flag |
| rx_data | output | 16 | Receive data register |

## Verification
On every cycle, the assertions check the following:
- a frame sets the receive flag and loads the data register;
- in FIFO mode the flag tracks the FIFO-full input;
- DMA-done clears the flag;
- an unarmed flag survives;
- the match flag never rises without the receive flag;
- an unarmed write of one leaves the match flag set.

Some behaviour is shown only by the bench's scenarios. This covers the full read handshakes, the equal and unequal values in both frame widths, the single evaluation per frame after a clear, and a clear that collides with a new frame.

// File: rtl/spi_rxs_pkg.sv
package spi_rxs_pkg;
    typedef enum logic [1:0] {
        RF_EMPTY = 2'd0,
        RF_FULL  = 2'd1,
        RF_ARMED = 2'd2
    } rf_state_t;

    typedef enum logic [1:0] {
        MF_CLEAR = 2'd0,
        MF_SET   = 2'd1,
        MF_ARMED = 2'd2
    } mf_state_t;
endpackage

// File: rtl/rxs_compare.sv
module rxs_compare #(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic [DATA_W-1:0] rx_value,
    input  logic [DATA_W-1:0] ref_value,
    input  logic              wide,
    output logic              hit
);
    localparam int UPPER_W = DATA_W - NARROW_W;

    logic low_eq;
    logic high_eq;

    assign low_eq = (rx_value[NARROW_W-1:0] == ref_value[NARROW_W-1:0]);

    generate
        if (UPPER_W > 0) begin : g_upper
            assign high_eq = (rx_value[DATA_W-1:NARROW_W] == ref_value[DATA_W-1:NARROW_W]);
        end else begin : g_no_upper
            assign high_eq = 1'b1;
        end
    endgenerate

    // Narrow frames ignore the upper byte entirely (R8).
    assign hit = low_eq & (high_eq | ~wide);
endmodule

// File: rtl/rxs_full_fsm.sv
module rxs_full_fsm
    import spi_rxs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fifo_mode,
    input  logic fifo_full,
    input  logic frame_done,
    input  logic stat_rd,
    input  logic data_rd,
    input  logic dma_en,
    input  logic dma_done,
    output logic full
);
    rf_state_t state_q;
    rf_state_t state_d;
    logic      clear_evt;

    always_comb begin
        clear_evt = dma_en ? dma_done : data_rd;
    end

    always_comb begin
        state_d = state_q;
        if (fifo_mode) begin
            state_d = fifo_full ? RF_FULL : RF_EMPTY;
        end else begin
            unique case (state_q)
                RF_EMPTY: begin
                    if (frame_done) state_d = RF_FULL;
                end
                RF_FULL: begin
                    if (dma_en && dma_done)
                        state_d = frame_done ? RF_FULL : RF_EMPTY;
                    else if (stat_rd)
                        state_d = RF_ARMED;
                end
                RF_ARMED: begin
                    if (clear_evt)
                        state_d = frame_done ? RF_FULL : RF_EMPTY;
                end
                default: state_d = RF_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RF_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        full = (state_q != RF_EMPTY);
    end

    p_frame_sets_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_mode && frame_done) |=> full);

    p_fifo_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_mode |=> (full == $past(fifo_full)));

    p_dma_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_mode && dma_en && dma_done && !frame_done && full) |=> !full);

    p_unarmed_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_mode && state_q == RF_FULL && !(dma_en && dma_done)) |=> full);

    p_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != 2'd3);
endmodule

// File: rtl/rxs_match_fsm.sv
module rxs_match_fsm
    import spi_rxs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic full,
    input  logic hit,
    input  logic frame_done,
    input  logic stat_rd,
    input  logic clr_wr,
    output logic match
);
    mf_state_t state_q;
    mf_state_t state_d;
    logic      pending_q;
    logic      eval;
    logic      set_evt;

    // One evaluation per frame, once the receive flag is already up (R7, R11).
    always_comb begin
        eval    = pending_q && full;
        set_evt = eval && hit;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MF_CLEAR: begin
                if (set_evt) state_d = MF_SET;
            end
            MF_SET: begin
                if (stat_rd) state_d = MF_ARMED;
            end
            MF_ARMED: begin
                if (clr_wr) state_d = set_evt ? MF_SET : MF_CLEAR;
            end
            default: state_d = MF_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= MF_CLEAR;
            pending_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (frame_done)  pending_q <= 1'b1;
            else if (eval)   pending_q <= 1'b0;
        end
    end

    always_comb begin
        match = (state_q != MF_CLEAR);
    end

    p_match_after_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match) |-> $past(full));

    p_w1_unarmed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MF_SET && clr_wr) |=> match);

    p_mstate_legal: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != 2'd3);
endmodule

// File: rtl/spi_rx_status.sv
module spi_rx_status #(
    parameter int DATA_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_done,
    input  logic [DATA_W-1:0] frame_data,
    input  logic              wide_mode,
    input  logic              fifo_mode,
    input  logic              fifo_full,
    input  logic              dma_rx_en,
    input  logic              dma_rx_done,
    input  logic              match_we,
    input  logic [DATA_W-1:0] match_wdata,
    input  logic              stat_rd,
    input  logic              data_rd,
    input  logic              stat_wr,
    input  logic              clr_match,
    output logic              rx_full,
    output logic              match_flag,
    output logic [DATA_W-1:0] rx_data
);
    logic [DATA_W-1:0] rx_data_q;
    logic [DATA_W-1:0] match_q;
    logic              hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data_q <= '0;
            match_q   <= '0;
        end else begin
            if (frame_done) rx_data_q <= frame_data;
            if (match_we)   match_q   <= match_wdata;
        end
    end

    assign rx_data = rx_data_q;

    rxs_compare #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_cmp (
        .rx_value  (rx_data_q),
        .ref_value (match_q),
        .wide      (wide_mode),
        .hit       (hit)
    );

    rxs_full_fsm u_full (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_mode  (fifo_mode),
        .fifo_full  (fifo_full),
        .frame_done (frame_done),
        .stat_rd    (stat_rd),
        .data_rd    (data_rd),
        .dma_en     (dma_rx_en),
        .dma_done   (dma_rx_done),
        .full       (rx_full)
    );

    rxs_match_fsm u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .full       (rx_full),
        .hit        (hit),
        .frame_done (frame_done),
        .stat_rd    (stat_rd),
        .clr_wr     (stat_wr && clr_match),
        .match      (match_flag)
    );

    p_data_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> (rx_data == $past(frame_data)));
endmodule

// File: tb/tb_spi_rx_status.sv
module tb_spi_rx_status;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        frame_done, wide_mode, fifo_mode, fifo_full;
    logic        dma_rx_en, dma_rx_done, match_we, stat_rd, data_rd, stat_wr, clr_match;
    logic [15:0] frame_data, match_wdata, rx_data;
    logic        rx_full, match_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    spi_rx_status dut (
        .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_data(frame_data),
        .wide_mode(wide_mode), .fifo_mode(fifo_mode), .fifo_full(fifo_full),
        .dma_rx_en(dma_rx_en), .dma_rx_done(dma_rx_done), .match_we(match_we),
        .match_wdata(match_wdata), .stat_rd(stat_rd), .data_rd(data_rd),
        .stat_wr(stat_wr), .clr_match(clr_match), .rx_full(rx_full),
        .match_flag(match_flag), .rx_data(rx_data)
    );

    typedef struct packed {
        logic        fd;
        logic [15:0] dat;
        logic        srd;
        logic        drd;
        logic        w1;
        logic        e_full;
        logic        e_match;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 16'h1234, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R2 frame, mismatch pending
        '{1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R7 mismatch stays clear
        '{1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R3 status read arms
        '{1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 data read clears
        '{1'b1, 16'hA55A, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R2 matching frame
        '{1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R7 match one cycle later
        '{1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R10 unarmed write ignored
        '{1'b0, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}, // R9 status read arms
        '{1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R9 write one clears
        '{1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R11 no re-set
        '{1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 armed data read clears
        '{1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}  // R3 read when empty
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        frame_done = 0; frame_data = '0; dma_rx_done = 0; match_we = 0;
        match_wdata = '0; stat_rd = 0; data_rd = 0; stat_wr = 0; clr_match = 0;
    endtask

    task automatic tick();
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic frame(input logic [15:0] v);
        frame_done = 1; frame_data = v; tick();
    endtask

    task automatic clear_both();
        stat_rd = 1; tick();
        data_rd = 1; stat_wr = 1; clr_match = 1; tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        wide_mode = 1; fifo_mode = 0; fifo_full = 0; dma_rx_en = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R1 rx_full", {15'd0, rx_full}, 16'd0);
        chk("R1 match_flag", {15'd0, match_flag}, 16'd0);
        chk("R1 rx_data", rx_data, 16'h0000);

        match_we = 1; match_wdata = 16'hA55A; tick();

        for (int i = 0; i < NV; i++) begin
            frame_done = VECS[i].fd; frame_data = VECS[i].dat;
            stat_rd = VECS[i].srd; data_rd = VECS[i].drd;
            stat_wr = VECS[i].w1; clr_match = VECS[i].w1;
            tick();
            chk($sformatf("vec%0d rx_full", i), {15'd0, rx_full}, {15'd0, VECS[i].e_full});
            chk($sformatf("vec%0d match_flag", i), {15'd0, match_flag}, {15'd0, VECS[i].e_match});
            if (VECS[i].fd) chk($sformatf("R2 vec%0d rx_data", i), rx_data, VECS[i].dat);
        end

        // R3: data read without a prior status read is ignored
        frame(16'h0001);
        data_rd = 1; tick();
        chk("R3 unarmed data read", {15'd0, rx_full}, 16'd1);
        clear_both();
        chk("R3 cleared", {15'd0, rx_full}, 16'd0);

        // R5: clear collides with new frame
        frame(16'h0002);
        stat_rd = 1; tick();
        data_rd = 1; frame_done = 1; frame_data = 16'h0003; tick();
        chk("R5 flag kept", {15'd0, rx_full}, 16'd1);
        chk("R5 new data", rx_data, 16'h0003);
        clear_both();

        // R8: narrow mode compares low byte only
        match_we = 1; match_wdata = 16'h77A5; tick();
        wide_mode = 0;
        frame(16'h11A5); tick();
        chk("R8 narrow match", {15'd0, match_flag}, 16'd1);
        clear_both();
        chk("R9 both cleared", {14'd0, rx_full, match_flag}, 16'd0);
        wide_mode = 1;
        frame(16'h11A5); tick();
        chk("R8 wide mismatch", {15'd0, match_flag}, 16'd0);
        clear_both();

        // R4: DMA mode
        dma_rx_en = 1;
        frame(16'h0004);
        stat_rd = 1; tick();
        data_rd = 1; tick();
        chk("R4 data read ignored in DMA", {15'd0, rx_full}, 16'd1);
        dma_rx_done = 1; tick();
        chk("R4 dma done clears", {15'd0, rx_full}, 16'd0);
        frame(16'h0005);
        dma_rx_done = 1; frame_done = 1; frame_data = 16'h0006; tick();
        chk("R5 dma clear with frame", {15'd0, rx_full}, 16'd1);
        dma_rx_done = 1; tick();
        dma_rx_en = 0;
        frame(16'h0007);
        dma_rx_done = 1; tick();
        chk("R4 dma done ignored when disabled", {15'd0, rx_full}, 16'd1);
        clear_both();

        // R6: FIFO mode
        fifo_mode = 1;
        frame(16'h0008);
        chk("R6 frame ignored in FIFO mode", {15'd0, rx_full}, 16'd0);
        fifo_full = 1; tick();
        chk("R6 follows fifo_full high", {15'd0, rx_full}, 16'd1);
        fifo_full = 0; tick();
        chk("R6 follows fifo_full low", {15'd0, rx_full}, 16'd0);
        fifo_mode = 0;

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule